// File: doc/BRIEF.md
# Queue-Aware Interrupt Status Unit

This block keeps the interrupt status byte and the interrupt mask byte of a packet network controller and drives one level-sensitive interrupt line. Most status bits are latched: a one-cycle set strobe from the datapath sets a bit, and the bit stays set until software acknowledges it or the datapath clears it.

Two bits also follow the occupancy of queues held outside the block. One shows that the transmit queue is empty. The other shows that the transmit completion queue holds entries. The status read path sees both bits in the same cycle that the queue lengths change.

Software clears bits by writing an acknowledge byte. Only a fixed subset of bits can be cleared this way. When the acknowledge write selects the transmit-done bit and the completion queue is not empty, the block issues a one-cycle pop strobe to that queue. Set strobes win over every clear in the same cycle, so a new event is never lost.

Top module: `irq_status_unit`

## Requirements
- R1: While reset is asserted and after it is released, status_o reads 0x04, mask_o reads 0x00 and irq_o is low, whatever the queue lengths are.
- R2: A set_i bit that is high at a clock edge sets the matching status_o bit from that edge on. The bit stays set after the strobe drops, until a clear reaches it.
- R3: Status bit 2 (transmit queue empty, 0x04) reads 1 in every cycle in which tx_len_i is zero, including the cycle in which tx_len_i first becomes zero.
- R4: Status bit 1 (transmit done, 0x02) reads 1 in every cycle in which done_len_i is non-zero. Once latched, it stays set after done_len_i returns to zero, until it is cleared.
- R5: In every cycle, irq_o is high exactly when status_o AND mask_o is non-zero.
- R6: An acknowledge write (ack_we_i) clears only the status bits in ack_data_i AND 0xD6, which are bits 1, 2, 4, 6 and 7. Bits 0 (0x01), 3 (0x08) and 5 (0x20) are not changed by an acknowledge write.
- R7: done_pop_o is high for exactly the cycles in which ack_we_i is high, ack_data_i bit 1 is set and done_len_i is non-zero.
- R8: When set_i and a clear (an acknowledge write or hw_clr_i) select the same bit in the same cycle, the bit ends up set.
- R9: A hw_clr_i bit that is high at a clock edge clears the matching status bit unless set_i sets that bit in the same cycle. A bit forced by R3 or R4 still reads 1 afterwards.
- R10: A mask write (mask_we_i) loads mask_data_i into mask_o at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| set_i | input | 8 | Per-bit set strobes from event sources |
| hw_clr_i | input | 8 | Per-bit clear strobes from the datapath |
| ack_we_i | input | 1 | Acknowledge byte write strobe |
| ack_data_i | input | 8 | Acknowledge byte |
| mask_we_i | input | 1 | Mask byte write strobe |
| mask_data_i | input | 8 | Mask byte write data |
| tx_len_i | input | LW | Transmit queue occupancy |
| done_len_i | input | LW | Transmit completion queue occupancy |
| status_o | output | 8 | Interrupt status byte |
| mask_o | output | 8 | Interrupt mask byte |
| irq_o | output | 1 | Level interrupt request |
| done_pop_o | output | 1 | Pop strobe to the completion queue |

## Verification
The checker tests, on every cycle, the relations that hold between ports at all times. These are the occupancy-forced bits, the interrupt level as the masked OR, the conditions that allow a pop, that set strobes always win, that the bits an acknowledge cannot reach stay unchanged, and that mask writes take effect. Only the directed scenarios can show the rest: the exact status byte that remains after an acknowledge, that a transmit-done bit stays latched once its queue drains, the reset values, and the cases where no pop is issued.

// File: rtl/irq_status_pkg.sv
package irq_status_pkg;
  localparam int unsigned SW = 8;
  localparam int unsigned BIT_RX_DONE  = 0;
  localparam int unsigned BIT_TX_DONE  = 1;
  localparam int unsigned BIT_TX_EMPTY = 2;
  localparam int unsigned BIT_ALLOC    = 3;
  localparam int unsigned BIT_RX_OVR   = 4;
  localparam logic [SW-1:0] ACK_CLEARABLE = 8'hD6;
  localparam logic [SW-1:0] STATUS_RESET  = 8'h04;
  typedef logic [SW-1:0] sts_t;
endpackage

// File: rtl/irq_occupancy.sv
module irq_occupancy
  import irq_status_pkg::*;
#(
  parameter int unsigned LW = 3
) (
  input  logic [LW-1:0] tx_len_i,
  input  logic [LW-1:0] done_len_i,
  output sts_t          forced_o,
  output logic          done_nonempty_o
);
  always_comb begin
    forced_o               = '0;
    forced_o[BIT_TX_EMPTY] = (tx_len_i == '0);
    forced_o[BIT_TX_DONE]  = (done_len_i != '0);
    done_nonempty_o        = (done_len_i != '0);
  end
endmodule

// File: rtl/irq_status_reg.sv
module irq_status_reg
  import irq_status_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  sts_t set_i,
  input  sts_t clr_i,
  input  sts_t forced_i,
  output sts_t sts_q_o
);
  for (genvar b = 0; b < SW; b++) begin : g_bit
    logic q;
    // set and occupancy win over clear
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q <= STATUS_RESET[b];
      else         q <= (q & ~clr_i[b]) | set_i[b] | forced_i[b];
    end
    assign sts_q_o[b] = q;
  end
endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg
  import irq_status_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic we_i,
  input  sts_t wdata_i,
  output sts_t mask_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   mask_o <= '0;
    else if (we_i) mask_o <= wdata_i;
  end
endmodule

// File: rtl/irq_status_unit.sv
module irq_status_unit
  import irq_status_pkg::*;
#(
  parameter int unsigned QDEPTH = 4,
  localparam int unsigned LW = $clog2(QDEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [7:0]    set_i,
  input  logic [7:0]    hw_clr_i,
  input  logic          ack_we_i,
  input  logic [7:0]    ack_data_i,
  input  logic          mask_we_i,
  input  logic [7:0]    mask_data_i,
  input  logic [LW-1:0] tx_len_i,
  input  logic [LW-1:0] done_len_i,
  output logic [7:0]    status_o,
  output logic [7:0]    mask_o,
  output logic          irq_o,
  output logic          done_pop_o
);
  sts_t forced, sts_q, clr, mask_q;
  logic done_nonempty;

  irq_occupancy #(.LW(LW)) u_occ (
    .tx_len_i        (tx_len_i),
    .done_len_i      (done_len_i),
    .forced_o        (forced),
    .done_nonempty_o (done_nonempty)
  );

  assign clr = hw_clr_i | (ack_we_i ? (ack_data_i & ACK_CLEARABLE) : '0);

  irq_status_reg u_sts (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .set_i    (set_i),
    .clr_i    (clr),
    .forced_i (forced),
    .sts_q_o  (sts_q)
  );

  irq_mask_reg u_mask (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (mask_we_i),
    .wdata_i (mask_data_i),
    .mask_o  (mask_q)
  );

  // occupancy bits visible in the same cycle; hold in reset at reset value
  assign status_o   = rst_ni ? (sts_q | forced) : STATUS_RESET;
  assign mask_o     = mask_q;
  assign irq_o      = |(status_o & mask_q);
  assign done_pop_o = ack_we_i & ack_data_i[BIT_TX_DONE] & done_nonempty;
endmodule

// File: rtl/irq_status_unit_chk.sv
module irq_status_unit_chk #(
  parameter int unsigned LW = 3
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [7:0]    set_i,
  input logic [7:0]    hw_clr_i,
  input logic          ack_we_i,
  input logic [7:0]    ack_data_i,
  input logic          mask_we_i,
  input logic [7:0]    mask_data_i,
  input logic [LW-1:0] tx_len_i,
  input logic [LW-1:0] done_len_i,
  input logic [7:0]    status_o,
  input logic [7:0]    mask_o,
  input logic          irq_o,
  input logic          done_pop_o
);
  assert_tx_empty_forced_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_len_i == '0) |-> status_o[2]);

  assert_tx_done_forced_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_len_i != '0) |-> status_o[1]);

  assert_irq_level_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == ((status_o & mask_o) != 8'h00));

  assert_fixed_bits_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_we_i && set_i == 8'h00 && hw_clr_i == 8'h00)
      |=> ((status_o & 8'h29) == ($past(status_o) & 8'h29)));

  assert_pop_nonempty_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_pop_o |-> (done_len_i != '0));

  assert_pop_on_ack_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_pop_o |-> (ack_we_i && ack_data_i[1]));

  assert_set_wins_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i != 8'h00) |=> ((status_o & $past(set_i)) == $past(set_i)));

  assert_mask_load_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mask_we_i |=> (mask_o == $past(mask_data_i)));
endmodule

bind irq_status_unit irq_status_unit_chk #(.LW(LW)) u_chk (.*);

// File: tb/irq_status_unit_test.sv
module irq_status_unit_test;
  localparam int CLK_P = 10;
  localparam int LW = 3;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [7:0]    set_i = '0, hw_clr_i = '0, ack_data_i = '0, mask_data_i = '0;
  logic          ack_we_i = 1'b0, mask_we_i = 1'b0;
  logic [LW-1:0] tx_len_i = 3'd2, done_len_i = '0;
  logic [7:0]    status_o, mask_o;
  logic          irq_o, done_pop_o;

  int n_chk = 0, n_bad = 0;
  bit finished = 1'b0;

  irq_status_unit #(.QDEPTH(4)) uut (.*);

  always #(CLK_P/2) clk_i = ~clk_i;

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic idle();
    set_i = '0; hw_clr_i = '0; ack_we_i = 0; ack_data_i = '0; mask_we_i = 0;
  endtask

  // zero all stored bits with non-empty tx queue and empty done queue
  task automatic clear_all();
    tx_len_i = 3'd2; done_len_i = '0; hw_clr_i = 8'hFF; step(); idle();
  endtask

  task automatic t_reset();
    #1;
    check("R1 status in reset", status_o, 8'h04);
    check("R1 mask in reset", mask_o, 8'h00);
    check("R1 irq in reset", {7'd0, irq_o}, 8'h00);
    step(); rst_ni = 1'b1; step();
    check("R1 status after reset", status_o, 8'h04);
  endtask

  task automatic t_set();
    clear_all();
    check("R9 cleared", status_o, 8'h00);
    set_i = 8'h01; step(); idle();
    check("R2 set bit0", status_o, 8'h01);
    step();
    check("R2 held", status_o, 8'h01);
  endtask

  task automatic t_occ();
    clear_all();
    tx_len_i = 3'd0; #1;
    check("R3 same cycle", status_o, 8'h04);
    step(); tx_len_i = 3'd2; ack_we_i = 1; ack_data_i = 8'h04; step(); idle();
    check("R6 tx_empty acked", status_o, 8'h00);
    done_len_i = 3'd1; #1;
    check("R4 same cycle", status_o, 8'h02);
    step(); done_len_i = 3'd0; step();
    check("R4 latched", status_o, 8'h02);
    ack_we_i = 1; ack_data_i = 8'h02; #1;
    check("R7 no pop empty", {7'd0, done_pop_o}, 8'h00);
    step(); idle();
    check("R6 tx_done acked", status_o, 8'h00);
    tx_len_i = 3'd0; hw_clr_i = 8'h04; step(); idle();
    check("R9 forced survives", status_o, 8'h04);
    tx_len_i = 3'd2;
  endtask

  task automatic t_ack();
    clear_all();
    set_i = 8'hFF; step(); idle();
    check("R2 all set", status_o, 8'hFF);
    ack_we_i = 1; ack_data_i = 8'hFF; step(); idle();
    check("R6 only D6 cleared", status_o, 8'h29);
    hw_clr_i = 8'h29; step(); idle();
    check("R9 hw clear", status_o, 8'h00);
  endtask

  task automatic t_prio();
    clear_all();
    set_i = 8'h10; ack_we_i = 1; ack_data_i = 8'h10; step(); idle();
    check("R8 set beats ack", status_o, 8'h10);
    set_i = 8'h08; hw_clr_i = 8'h18; step(); idle();
    check("R8 set beats hw clear", status_o, 8'h08);
  endtask

  task automatic t_mask();
    clear_all();
    mask_we_i = 1; mask_data_i = 8'h10; step(); idle();
    check("R10 mask loaded", mask_o, 8'h10);
    check("R5 irq low", {7'd0, irq_o}, 8'h00);
    set_i = 8'h10; step(); idle();
    check("R5 irq high", {7'd0, irq_o}, 8'h01);
    mask_we_i = 1; mask_data_i = 8'h01; step(); idle();
    check("R5 irq masked", {7'd0, irq_o}, 8'h00);
    tx_len_i = 3'd0; mask_we_i = 1; mask_data_i = 8'h04; step(); idle();
    check("R5 irq from occupancy", {7'd0, irq_o}, 8'h01);
    tx_len_i = 3'd2;
  endtask

  task automatic t_pop();
    clear_all();
    done_len_i = 3'd2; ack_we_i = 1; ack_data_i = 8'h02; #1;
    check("R7 pop", {7'd0, done_pop_o}, 8'h01);
    ack_data_i = 8'h04; #1;
    check("R7 no pop wrong bit", {7'd0, done_pop_o}, 8'h00);
    step(); idle(); #1;
    check("R7 pop one cycle", {7'd0, done_pop_o}, 8'h00);
    done_len_i = '0;
  endtask

  initial begin
    t_reset();
    t_set();
    t_occ();
    t_ack();
    t_prio();
    t_mask();
    t_pop();
    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_P * 100000);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule